// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects forty-one interrupt sources for a small processor core, holds a priority level for each, and remembers which sources are waiting for service. A set of fixed external lines and a non-maskable line carry built-in priorities. The on-chip peripherals take their priority from three 16-bit priority registers. Several peripherals share one 4-bit field in these registers. A combinational arbiter picks one winner from the waiting sources. A request line goes to the core when the core's block bit and its current mask level allow that winner through.

The core queries the winner with an accept strobe. One cycle later the block shows the winner's 12-bit exception code, with a valid flag. Accepting a source does not remove it. Software or the servicing logic removes it with an explicit clear strobe that carries the source index.

A small two-state machine drives the code output. In ST_IDLE no code is shown. The transition T_ACCEPT goes from either state to ST_PRESENT when accept is high and something is pending. The transition T_DROP goes from ST_PRESENT back to ST_IDLE on any cycle without such an accept.

Top module: `intc_ctrl`

## Requirements
- R1: After reset the pending set is empty, irq_req and code_valid are 0, and all four registers read 0. External line k (k = 0..14, index k) has priority 15-k. The non-maskable line (index 15) has priority 16. Every peripheral source has priority 0.
- R2: Writing with reg_wr at reg_addr 0 (control), 1 (prio A), 2 (prio B) or 3 (prio C) stores all 16 bits. reg_rdata combinationally shows the register selected by reg_addr.
- R3: Field layout. Prio A [15:12] sets timer 0 (23). A [11:8] sets timer 1 (24). A [7:4] sets timer 2 (25) and input capture (26). A [3:0] sets RTC 27..29. Prio B [15:12] sets the watchdog (38). B [11:8] sets refresh 39..40. B [7:4] sets serial 30..33. B [3:0] assigns nothing. Prio C [15:12] sets GPIO (17). C [11:8] sets DMA 18..22. C [7:4] sets FIFO serial 34..37. C [3:0] sets debug (16).
- R4: A raise of a source whose priority is 0 is ignored. The source stays absent even if its priority is raised later.
- R5: A source raised again while it is pending is held once. A single clear empties it.
- R6: clr_en with clr_id = n removes source n on the next edge. A raise of n in that same cycle wins, and n stays pending.
- R7: The winner is the pending source with the highest priority. A tie goes to the lower index.
- R8: irq_req is 1 exactly when a source is pending, cpu_block is 0, and cpu_mask is strictly less than the winner's priority. It follows changes in mask, block and pending set in the same cycle.
- R9: accept with a non-empty set gives code_valid = 1 and the winner's code in the next cycle. The source stays pending. accept with an empty set gives code_valid = 0.
- R10: Codes are as follows. Index k < 15 gives 0x200+0x20·k. Index 15 gives 0x1C0, 16 gives 0x600 and 17 gives 0x620. Indices 18..22 give 0x640+0x20·(n-18). Indices 23..33 give 0x400+0x20·(n-23). Indices 34..37 give 0x700+0x20·(n-34). Indices 38..40 give 0x560+0x20·(n-38).
- R11: A write to the control register has no effect other than its readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| src_raise | input | 41 | Per-source raise strobes |
| clr_en | input | 1 | Clear strobe |
| clr_id | input | 6 | Index of the source to clear |
| cpu_block | input | 1 | Core block bit |
| cpu_mask | input | 4 | Core interrupt mask level |
| irq_req | output | 1 | Request to the core |
| accept | input | 1 | Accept query strobe |
| code_valid | output | 1 | Exception code valid |
| code | output | 12 | Exception code of the winner |

## Verification
Every source is raised alone. This exposes any misplaced field, wrong code or source that fails to mask. Every pair of sources is then raised together, and the expected winner is computed from the programmed priorities. The pairs include peripherals that share a field and external lines whose level equals a peripheral field, so the index tie-break is separated from the priority order. A sweep of all mask levels under both block values, against a mid-level line and the non-maskable line, pins down the strict comparison. Short directed sequences cover duplicate raises, clear-against-raise and repeated accepts.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NUM_SRC   = 41;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int PRIO_W    = 5;
    localparam int NIB_W     = 4;
    localparam int CODE_W    = 12;
    localparam int REG_W     = 16;
    localparam int ADDR_W    = 2;
    localparam int NUM_REGS  = 1 << ADDR_W;
    localparam int EXT_LINES = 15;
    localparam int NMI_IDX   = 15;
    localparam int NMI_PRIO  = 16;
    localparam int CODE_STEP = 32;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [REG_W-1:0]  word_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 2'd0,
        RA_PRIO_A = 2'd1,
        RA_PRIO_B = 2'd2,
        RA_PRIO_C = 2'd3
    } reg_addr_e;

    // exception code of a source index
    function automatic code_t src_code(input int n);
        int base;
        int off;
        if (n < EXT_LINES) begin
            base = 'h200; off = n;
        end else if (n == NMI_IDX) begin
            base = 'h1C0; off = 0;
        end else if (n == 16) begin
            base = 'h600; off = 0;
        end else if (n == 17) begin
            base = 'h620; off = 0;
        end else if (n <= 22) begin
            base = 'h640; off = n - 18;
        end else if (n <= 33) begin
            base = 'h400; off = n - 23;
        end else if (n <= 37) begin
            base = 'h700; off = n - 34;
        end else begin
            base = 'h560; off = n - 38;
        end
        return code_t'(base + CODE_STEP * off);
    endfunction
endpackage

// File: rtl/intc_prio_regs.sv
module intc_prio_regs
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  word_t             wdata_i,
    output word_t             rdata_o,
    output prio_t             prio_o [NUM_SRC]
);
    word_t regs_q [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) regs_q[r] <= '0;
        end else if (wr_i) begin
            regs_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = regs_q[addr_i];

    function automatic prio_t nib(input word_t w, input int k);
        return prio_t'(w[k*NIB_W +: NIB_W]);
    endfunction

    word_t ra, rb, rc;
    assign ra = regs_q[RA_PRIO_A];
    assign rb = regs_q[RA_PRIO_B];
    assign rc = regs_q[RA_PRIO_C];

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            if (i < EXT_LINES) begin
                prio_o[i] = prio_t'(EXT_LINES - i);
            end else if (i == NMI_IDX) begin
                prio_o[i] = prio_t'(NMI_PRIO);
            end else begin
                case (i) inside
                    16:       prio_o[i] = nib(rc, 0);
                    17:       prio_o[i] = nib(rc, 3);
                    [18:22]:  prio_o[i] = nib(rc, 2);
                    23:       prio_o[i] = nib(ra, 3);
                    24:       prio_o[i] = nib(ra, 2);
                    [25:26]:  prio_o[i] = nib(ra, 1);
                    [27:29]:  prio_o[i] = nib(ra, 0);
                    [30:33]:  prio_o[i] = nib(rb, 1);
                    [34:37]:  prio_o[i] = nib(rc, 1);
                    38:       prio_o[i] = nib(rb, 3);
                    [39:40]:  prio_o[i] = nib(rb, 2);
                    default:  prio_o[i] = '0;
                endcase
            end
        end
    end

    // R2: a write shows up on the readback of the same address next cycle
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !$isunknown(addr_i)) |=> (regs_q[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/intc_pending.sv
module intc_pending
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] raise_i,
    input  logic               clr_en_i,
    input  idx_t               clr_id_i,
    input  prio_t              prio_i [NUM_SRC],
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] pend_d;
    logic [NUM_SRC-1:0] clr_hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        assign clr_hit[g] = clr_en_i && (clr_id_i == idx_t'(g));
        assign pend_d[g]  = (pend_q[g] && !clr_hit[g]) ||
                            (raise_i[g] && (prio_i[g] != '0));

        // R4: a raise at priority 0 never creates an entry
        p_masked_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (raise_i[g] && prio_i[g] == '0 && !pend_q[g]) |=> !pend_q[g]);
        // R6: a clear without a same-cycle raise removes the entry
        p_clear_removes_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en_i && clr_id_i == idx_t'(g) && !raise_i[g]) |=> !pend_q[g]);
        // R5: an entry persists until it is cleared
        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[g] && !(clr_en_i && clr_id_i == idx_t'(g))) |=> pend_q[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  prio_t              prio_i [NUM_SRC],
    output logic               any_o,
    output idx_t               win_idx_o,
    output prio_t              win_prio_o
);
    always_comb begin
        any_o      = 1'b0;
        win_idx_o  = '0;
        win_prio_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            // strict compare keeps the lower index on a tie
            if (pend_i[i] && (!any_o || prio_i[i] > win_prio_o)) begin
                any_o      = 1'b1;
                win_idx_o  = idx_t'(i);
                win_prio_o = prio_i[i];
            end
        end
    end

    // R7: the chosen winner is a pending source
    p_winner_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> pend_i[win_idx_o]);
    // R7: an empty set names no winner
    p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |-> !any_o);
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_SRC-1:0] src_raise,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_id,
    input  logic               cpu_block,
    input  logic [NIB_W-1:0]   cpu_mask,
    output logic               irq_req,
    input  logic               accept,
    output logic               code_valid,
    output logic [CODE_W-1:0]  code
);
    typedef enum logic {ST_IDLE, ST_PRESENT} pres_state_e;

    prio_t              prio_w [NUM_SRC];
    logic [NUM_SRC-1:0] pend_w;
    logic               any_w;
    idx_t               win_idx_w;
    prio_t              win_prio_w;
    pres_state_e        state_q, state_d;
    code_t              code_q;

    intc_prio_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .prio_o  (prio_w)
    );

    intc_pending u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise_i  (src_raise),
        .clr_en_i (clr_en),
        .clr_id_i (clr_id),
        .prio_i   (prio_w),
        .pend_o   (pend_w)
    );

    intc_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend_w),
        .prio_i     (prio_w),
        .any_o      (any_w),
        .win_idx_o  (win_idx_w),
        .win_prio_o (win_prio_w)
    );

    assign irq_req = any_w && !cpu_block && (prio_t'(cpu_mask) < win_prio_w);

    // next-state logic: T_ACCEPT / T_DROP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = (accept && any_w) ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: state_d = (accept && any_w) ? ST_PRESENT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept && any_w) code_q <= src_code(int'(win_idx_w));
        end
    end

    // output process
    always_comb begin
        code_valid = (state_q == ST_PRESENT);
        code       = code_q;
    end

    // R8: the request needs an unblocked core and a pending source
    p_req_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (!cpu_block && pend_w != '0));
    // R9: a valid code only follows an accept
    p_code_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> $past(accept));
    // R9: accepting does not remove anything
    p_accept_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pend_w != '0 && !clr_en) |=> (pend_w != '0));
endmodule

// File: tb/tb_intc_ctrl.sv
module tb_intc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [40:0] src_raise = '0;
    logic        clr_en = 1'b0;
    logic [5:0]  clr_id = '0;
    logic        cpu_block = 1'b0;
    logic [3:0]  cpu_mask = '0;
    logic        irq_req;
    logic        accept = 1'b0;
    logic        code_valid;
    logic [11:0] code;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] ra = 16'h5A3C, rb = 16'h7E61, rc = 16'h9B40;

    always #2 clk = ~clk;

    intc_ctrl dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int e_prio(input int n);
        if (n < 15) return 15 - n;
        if (n == 15) return 16;
        if (n == 16) return rc[3:0];
        if (n == 17) return rc[15:12];
        if (n <= 22) return rc[11:8];
        if (n == 23) return ra[15:12];
        if (n == 24) return ra[11:8];
        if (n <= 26) return ra[7:4];
        if (n <= 29) return ra[3:0];
        if (n <= 33) return rb[7:4];
        if (n <= 37) return rc[7:4];
        if (n == 38) return rb[15:12];
        return rb[11:8];
    endfunction

    function automatic int e_code(input int n);
        if (n < 15)  return 'h200 + n * 'h20;
        if (n == 15) return 'h1C0;
        if (n == 16) return 'h600;
        if (n == 17) return 'h620;
        if (n <= 22) return 'h640 + (n - 18) * 'h20;
        if (n <= 33) return 'h400 + (n - 23) * 'h20;
        if (n <= 37) return 'h700 + (n - 34) * 'h20;
        return 'h560 + (n - 38) * 'h20;
    endfunction

    task automatic wr(input int a, input logic [15:0] d);
        reg_addr = 2'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input int a, input int exp);
        reg_addr = 2'(a);
        #0.5;
        chk(req, reg_rdata, exp);
    endtask

    task automatic raise2(input int i, input int j);
        src_raise = '0;
        src_raise[i] = 1'b1;
        src_raise[j] = 1'b1;
        @(negedge clk);
        src_raise = '0;
    endtask

    task automatic clr(input int i);
        clr_en = 1'b1; clr_id = 6'(i);
        @(negedge clk);
        clr_en = 1'b0;
    endtask

    task automatic acc();
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq_req", irq_req, 0);
        chk("R1 code_valid", code_valid, 0);
        for (int a = 0; a < 4; a++) rd("R1 reg reset", a, 0);
        // R1 peripheral masked at reset
        raise2(23, 23);
        chk("R1 timer masked", irq_req, 0);
        acc();
        chk("R1 empty accept", code_valid, 0);

        // R2 register writes and readback
        wr(1, ra); wr(2, rb); wr(3, rc); wr(0, 16'h0000);
        rd("R2 read A", 1, ra);
        rd("R2 read B", 2, rb);
        rd("R2 read C", 3, rc);
        rd("R2 read ctrl", 0, 0);

        // R3 R10 single-source sweep
        for (int i = 0; i < 41; i++) begin
            raise2(i, i);
            chk("R3 single irq", irq_req, e_prio(i) > 0);
            acc();
            chk("R10 single valid", code_valid, e_prio(i) > 0);
            if (e_prio(i) > 0) chk("R10 single code", code, e_code(i));
            clr(i);
            chk("R6 cleared", irq_req, 0);
        end

        // R4 masked source stays absent after unmasking
        raise2(16, 16);
        wr(3, {rc[15:4], 4'hF});
        chk("R4 stays absent", irq_req, 0);
        acc();
        chk("R4 no code", code_valid, 0);
        wr(3, rc);

        // R7 pairwise arbitration
        for (int i = 0; i < 41; i++) begin
            for (int j = i + 1; j < 41; j++) begin
                int w;
                raise2(i, j);
                w = -1;
                if (e_prio(i) > 0) w = i;
                if (e_prio(j) > 0 && (w < 0 || e_prio(j) > e_prio(i))) w = j;
                acc();
                chk("R7 pair valid", code_valid, w >= 0);
                if (w >= 0) chk("R7 pair winner", code, e_code(w));
                clr(i); clr(j);
            end
        end

        // R8 mask and block sweep on line 5 (priority 10)
        raise2(5, 5);
        for (int b = 0; b < 2; b++) begin
            for (int m = 0; m < 16; m++) begin
                cpu_block = 1'(b); cpu_mask = 4'(m);
                @(negedge clk);
                chk("R8 mask sweep", irq_req, (b == 0) && (m < 10));
            end
        end
        clr(5);
        // R8 non-maskable line beats mask 15
        raise2(15, 15);
        cpu_block = 1'b0; cpu_mask = 4'hF;
        @(negedge clk);
        chk("R8 nmi mask15", irq_req, 1);
        cpu_block = 1'b1;
        @(negedge clk);
        chk("R8 nmi blocked", irq_req, 0);
        cpu_block = 1'b0; cpu_mask = 4'h0;
        clr(15);

        // R5 duplicate raise, single clear
        raise2(3, 3); raise2(3, 3);
        clr(3);
        chk("R5 one clear empties", irq_req, 0);
        acc();
        chk("R5 no code", code_valid, 0);

        // R6 clear and raise in the same cycle
        raise2(7, 7);
        clr_en = 1'b1; clr_id = 6'd7; src_raise = '0; src_raise[7] = 1'b1;
        @(negedge clk);
        clr_en = 1'b0; src_raise = '0;
        acc();
        chk("R6 raise wins", code, 'h2E0);
        clr(7);

        // R9 accept keeps source
        raise2(2, 2);
        acc();
        chk("R9 first accept", code, 'h240);
        acc();
        chk("R9 second valid", code_valid, 1);
        chk("R9 second accept", code, 'h240);
        @(negedge clk);
        chk("R9 valid drops", code_valid, 0);

        // R11 control write has no side effect
        wr(0, 16'hFFFF);
        chk("R11 irq kept", irq_req, 1);
        rd("R11 ctrl readback", 0, 'hFFFF);
        acc();
        chk("R11 code kept", code, 'h240);
        clr(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule